// File: doc/BRIEF.md
# Page-Mode Parallel NOR Flash Read Controller

This block sits on the host side of an asynchronous parallel NOR flash. It accepts single 16-bit word reads over a valid/ready request channel, drives the flash address and control pins, waits the right number of clock cycles, samples the data bus and returns the word as a one-cycle response pulse. Only one read is in flight at a time.

The flash senses an eight-word group into an internal page buffer. Words in that group can then be fetched again, in any order, with a short page access delay. The controller keeps a tag and a valid flag for the group it believes is open. An array read whose upper address bits match a valid tag is timed with the short delay. Any other read is timed with the full initial access delay. The page is forgotten when chip enable is released after an idle timeout, when software pulses the invalidate input (for example after a program or erase operation elsewhere that left the flash in a non-array read state), and after a register-type read, which loads only one word.

Top module: `nor_page_reader`

## Requirements
- R1: While `rst_n` is low, `flash_ce_n`, `flash_oe_n` and `flash_we_n` are 1, `flash_rst_n` is 0, `rsp_valid` is 0 and `req_ready` is 1. After reset is released, `flash_rst_n` is 1.
- R2: The first array read after reset is a page miss. `rsp_valid` rises exactly `INIT_CYC` clock cycles after the cycle in which the request was accepted.
- R3: An array read (`req_reg`=0) whose address bits [AW-1:3] equal those of the previous array read, with the page still valid, is a hit. Its response comes exactly `PAGE_CYC` cycles after acceptance. This holds for any word order and for repeated words.
- R4: A read whose address bits [AW-1:3] differ from the open group is timed with the full `INIT_CYC` delay.
- R5: `flash_addr` equals the request address for the whole access. `rsp_data` is the value on `flash_dq` in the final cycle of the access.
- R6: During an access `flash_ce_n`=0, `flash_oe_n`=0, `flash_we_n`=1, `flash_adv_n`=0 and `flash_rst_n`=1. OE# is never low while CE# is high.
- R7: A register-type read (`req_reg`=1) always takes `INIT_CYC` cycles and leaves no valid page. The next array read, even in the same group, takes `INIT_CYC`.
- R8: A one-cycle pulse on `invalidate` while idle makes the next read take `INIT_CYC`.
- R9: If no request is accepted within `IDLE_CYC`+1 cycles after a response, CE# and OE# go high and the page is dropped. The next read takes `INIT_CYC`.
- R10: `req_ready` is low from the cycle after acceptance through the cycle in which `rsp_valid` is high. `rsp_valid` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | AW | Word address of the read |
| req_reg | input | 1 | Request is a register-type read (never a page hit) |
| invalidate | input | 1 | Forget the open page |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DW | Word returned |
| flash_addr | output | AW | Flash word address |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, held high |
| flash_adv_n | output | 1 | Flash address valid, held low |
| flash_rst_n | output | 1 | Flash reset, active low |
| flash_dq | input | DW | Flash data bus |

## Verification
A tag or valid flag that wrongly claims a hit shows up at once, on the first read of a fresh group: the response arrives after `PAGE_CYC` instead of `INIT_CYC` cycles, and the bench's flash model returns a poison word because the group has not been sensed long enough. A flag that is never set costs nothing in data but stretches every hit to the full delay, so the latency check fails on the second read of any group. A missed clear after the idle timeout, after a register read or after an invalidate pulse is seen on the very next read in the same group.

// File: rtl/nor_pg_pkg.sv
package nor_pg_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } rd_state_e;

    localparam int WORD_BITS = 3;
endpackage

// File: rtl/nor_pg_timer.sv
module nor_pg_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R2
    cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/nor_pg_tag.sv
module nor_pg_tag #(
    parameter int TW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          set,
    input  logic [TW-1:0] set_tag,
    input  logic [TW-1:0] look_tag,
    output logic          hit,
    output logic          valid
);
    typedef struct packed {
        logic          vld;
        logic [TW-1:0] tag;
    } tag_t;

    tag_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clr) begin
            t_d.vld = 1'b0;
        end else if (set) begin
            t_d.vld = 1'b1;
            t_d.tag = set_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign valid = t_q.vld;
    assign hit   = t_q.vld && (t_q.tag == look_tag);

    // R8
    clr_drops_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !valid);
endmodule

// File: rtl/nor_page_reader.sv
module nor_page_reader #(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int INIT_CYC = 6,
    parameter int PAGE_CYC = 3,
    parameter int IDLE_CYC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_reg,
    input  logic          invalidate,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] flash_addr,
    output logic          flash_ce_n,
    output logic          flash_oe_n,
    output logic          flash_we_n,
    output logic          flash_adv_n,
    output logic          flash_rst_n,
    input  logic [DW-1:0] flash_dq
);
    import nor_pg_pkg::*;

    localparam int TW      = AW - WORD_BITS;
    localparam int ACC_MAX = (INIT_CYC > PAGE_CYC) ? INIT_CYC : PAGE_CYC;
    localparam int ACW     = $clog2(ACC_MAX + 1);
    localparam int ICW     = $clog2(IDLE_CYC + 1);
    localparam logic [ACW-1:0] INIT_LD = ACW'(INIT_CYC - 1);
    localparam logic [ACW-1:0] PAGE_LD = ACW'(PAGE_CYC - 1);
    localparam logic [ICW-1:0] IDLE_LD = ICW'(IDLE_CYC - 1);

    typedef struct packed {
        rd_state_e     st;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          rsp;
        logic          ce_n;
        logic          oe_n;
        logic          is_reg;
        logic          frst_n;
    } ctl_t;

    ctl_t c_d, c_q;

    logic           accept, capture, timeout;
    logic           pg_hit, pg_valid, use_page;
    logic           acc_load, acc_done;
    logic [ACW-1:0] acc_val;
    logic           idle_load, idle_done;
    logic           tag_set, tag_clr;

    assign req_ready = (c_q.st == ST_IDLE) && !c_q.rsp;
    assign accept    = req_valid && req_ready;
    assign capture   = (c_q.st == ST_ACCESS) && acc_done;
    assign use_page  = pg_hit && !req_reg && !c_q.ce_n;
    assign timeout   = (c_q.st == ST_IDLE) && !c_q.rsp && !c_q.ce_n
                       && idle_done && !accept;

    assign acc_load  = accept;
    assign acc_val   = use_page ? PAGE_LD : INIT_LD;
    assign idle_load = (c_q.st != ST_IDLE) || c_q.rsp || accept || c_q.ce_n;

    assign tag_set   = capture && !c_q.is_reg && !invalidate;
    assign tag_clr   = invalidate || timeout || (capture && c_q.is_reg);

    nor_pg_timer #(.CW(ACW)) acc_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acc_load),
        .load_val (acc_val),
        .done     (acc_done)
    );

    nor_pg_timer #(.CW(ICW)) idle_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (idle_load),
        .load_val (IDLE_LD),
        .done     (idle_done)
    );

    nor_pg_tag #(.TW(TW)) tag_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tag_clr),
        .set      (tag_set),
        .set_tag  (c_q.addr[AW-1:WORD_BITS]),
        .look_tag (req_addr[AW-1:WORD_BITS]),
        .hit      (pg_hit),
        .valid    (pg_valid)
    );

    always_comb begin
        c_d        = c_q;
        c_d.rsp    = 1'b0;
        c_d.frst_n = 1'b1;
        unique case (c_q.st)
            ST_IDLE: begin
                if (accept) begin
                    c_d.st     = ST_ACCESS;
                    c_d.addr   = req_addr;
                    c_d.is_reg = req_reg;
                    c_d.ce_n   = 1'b0;
                    c_d.oe_n   = 1'b0;
                end else if (timeout) begin
                    c_d.ce_n   = 1'b1;
                    c_d.oe_n   = 1'b1;
                end
            end
            ST_ACCESS: begin
                if (acc_done) begin
                    c_d.st   = ST_IDLE;
                    c_d.data = flash_dq;
                    c_d.rsp  = 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st     <= ST_IDLE;
            c_q.addr   <= '0;
            c_q.data   <= '0;
            c_q.rsp    <= 1'b0;
            c_q.ce_n   <= 1'b1;
            c_q.oe_n   <= 1'b1;
            c_q.is_reg <= 1'b0;
            c_q.frst_n <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rsp_valid   = c_q.rsp;
    assign rsp_data    = c_q.data;
    assign flash_addr  = c_q.addr;
    assign flash_ce_n  = c_q.ce_n;
    assign flash_oe_n  = c_q.oe_n;
    assign flash_we_n  = 1'b1;
    assign flash_adv_n = 1'b0;
    assign flash_rst_n = c_q.frst_n;

    // R10
    rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!req_ready && !rsp_valid));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == ST_ACCESS) && $past(c_q.st == ST_ACCESS)) |-> $stable(flash_addr));

    // R6
    oe_within_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_oe_n |-> !flash_ce_n);

    // R9
    ce_release_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_ce_n) |-> !pg_valid);

    // R7
    reg_read_no_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && c_q.is_reg) |-> !pg_valid);
endmodule

// File: tb/nor_page_reader_tb.sv
module nor_page_reader_tb_top;
    localparam int AW   = 16;
    localparam int DW   = 16;
    localparam int INIT = 6;
    localparam int PAGE = 3;
    localparam int IDLE = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_reg = 1'b0;
    logic          invalidate = 1'b0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] flash_addr;
    logic          flash_ce_n, flash_oe_n, flash_we_n, flash_adv_n, flash_rst_n;
    logic [DW-1:0] flash_dq;

    always #4 clk = ~clk;

    nor_page_reader #(.AW(AW), .DW(DW), .INIT_CYC(INIT), .PAGE_CYC(PAGE),
                      .IDLE_CYC(IDLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_reg(req_reg), .invalidate(invalidate),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .flash_addr(flash_addr),
        .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
        .flash_adv_n(flash_adv_n), .flash_rst_n(flash_rst_n), .flash_dq(flash_dq)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return (a * 16'h03A5) ^ 16'h05C3 ^ {a[7:0], a[15:8]};
    endfunction

    // Flash model: data is only correct once the group and word have settled.
    logic [AW-4:0] prev_up = '0;
    logic [2:0]    prev_lo = '0;
    logic          prev_ce_n = 1'b1;
    int            s_age = 0, w_age = 0;

    always @(posedge clk) begin
        prev_up   <= flash_addr[AW-1:3];
        prev_lo   <= flash_addr[2:0];
        prev_ce_n <= flash_ce_n;
        if (flash_ce_n || prev_ce_n || flash_addr[AW-1:3] != prev_up) s_age <= 0;
        else if (s_age < 1000) s_age <= s_age + 1;
        if (flash_ce_n || prev_ce_n || flash_addr != {prev_up, prev_lo}) w_age <= 0;
        else if (w_age < 1000) w_age <= w_age + 1;
    end

    assign flash_dq = (!flash_ce_n && !flash_oe_n && s_age >= INIT - 2 && w_age >= PAGE - 2)
                      ? pat(flash_addr) : 16'hDEAD;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0, nfail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        int            lat;
        int            acc;
        string         rq;
    } item_t;

    item_t exp_q[$];

    logic          b_valid = 1'b0;
    logic [AW-4:0] b_tag = '0;

    task automatic rd(input logic [AW-1:0] a, input bit rg, input string rq);
        item_t it;
        bit    hit;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_reg   = rg;
        while (!req_ready) @(negedge clk);
        hit    = b_valid && (b_tag == a[AW-1:3]) && !rg;
        it.a   = a;
        it.d   = pat(a);
        it.lat = hit ? PAGE : INIT;
        it.acc = cyc + 1;
        it.rq  = rq;
        exp_q.push_back(it);
        b_valid = !rg;
        b_tag   = a[AW-1:3];
        @(negedge clk);
        req_valid = 1'b0;
        // R10
        check(!req_ready && !rsp_valid, "R10", "ready/rsp after accept",
              {req_ready, rsp_valid}, 0);
    endtask

    task automatic wait_idle();
        while (!req_ready || exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic pulse_inval();
        wait_idle();
        @(negedge clk);
        invalidate = 1'b1;
        @(negedge clk);
        invalidate = 1'b0;
        b_valid = 1'b0;
    endtask

    task automatic idle_out();
        wait_idle();
        repeat (IDLE + 4) @(negedge clk);
        // R9
        check(flash_ce_n && flash_oe_n, "R9", "ce_n/oe_n after idle timeout",
              {flash_ce_n, flash_oe_n}, 3);
        b_valid = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected response", 1, 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(rsp_data == it.d, it.rq, "data", rsp_data, it.d);
                check(cyc - it.acc == it.lat, it.rq, "latency", cyc - it.acc, it.lat);
                // R5
                check(flash_addr == it.a, "R5", "address held", flash_addr, it.a);
                // R6
                check(!flash_ce_n && !flash_oe_n && flash_we_n && !flash_adv_n && flash_rst_n,
                      "R6", "pins during access",
                      {flash_ce_n, flash_oe_n, flash_we_n, flash_adv_n, flash_rst_n}, 5'b00101);
                // R10
                check(!req_ready, "R10", "ready during response", req_ready, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (4) @(negedge clk);
        // R1
        check(flash_ce_n && flash_oe_n && flash_we_n && !flash_rst_n && !rsp_valid && req_ready,
              "R1", "reset pin state",
              {flash_ce_n, flash_oe_n, flash_we_n, flash_rst_n, rsp_valid, req_ready}, 6'b111001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(flash_rst_n, "R1", "flash reset released", flash_rst_n, 1);

        rd(16'h0120, 1'b0, "R2");
        rd(16'h0123, 1'b0, "R3");
        rd(16'h0121, 1'b0, "R3");
        rd(16'h0127, 1'b0, "R3");
        rd(16'h0121, 1'b0, "R3");
        rd(16'h0120, 1'b0, "R3");
        rd(16'h0128, 1'b0, "R4");
        rd(16'h012C, 1'b0, "R3");
        rd(16'h0528, 1'b0, "R4");
        rd(16'h052A, 1'b1, "R7");
        rd(16'h052B, 1'b0, "R7");
        rd(16'h052C, 1'b0, "R3");
        pulse_inval();
        rd(16'h052D, 1'b0, "R8");
        rd(16'h052E, 1'b0, "R3");
        idle_out();
        rd(16'h052F, 1'b0, "R9");
        rd(16'h0528, 1'b0, "R3");

        lf = 16'hACE1;
        for (int i = 0; i < 24; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            rd({12'h3C0, lf[4], lf[2:0]}, (lf[9:7] == 3'b101), "R3");
        end

        wait_idle();
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10", "responses outstanding", exp_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule